// File: doc/BRIEF.md
# UART Receive Queue with Per-Entry Error Tags

This block sits between the character assembler of a UART receiver and the CPU-facing receive registers. Each completed character arrives as a one-cycle strobe with eight data bits, the sampled parity bit and the sampled stop bit. The block checks parity and framing, then stores the character and its error tags together in a four-entry first-in first-out queue. The head entry is always presented as read data. Its tags move into the sticky status latches only once that entry has become the head.

When a character completes while the queue is full and no read happens in that cycle, the character is discarded. The overrun tag is then placed on the newest stored entry, and intake is frozen. It stays frozen until that entry reaches the head and raises the overrun latch, and software then clears the latches with the error-clear strobe. A receive interrupt is raised from the data-full flag, and optionally from a start-bit detect pulse.

Top module: `uart_rxq_top`

## Requirements
- R1: `data_full` becomes 1 in the cycle after a character is stored. It stays 1 while entries remain after a read, and it returns to 0 only in the cycle after a read that leaves the queue empty.
- R2: A character that has a parity or framing error is still stored, and it still raises `data_full`.
- R3: A stop-bit sample of 0 tags the character with a framing error.
- R4: With `par_en`=1, the XOR of the eight data bits and the parity bit must equal `par_odd` (0 selects even, 1 selects odd); any other result tags a parity error. With `par_en`=0, no parity error is ever tagged.
- R5: The tags of an entry reach `par_err`, `frm_err` and `ovr_err` one cycle after that entry has become the head, and never earlier.
- R6: A character that completes while all 4 entries are full, with no read in the same cycle, is dropped, and the overrun tag is set on the most recently stored entry.
- R7: After an overrun, every completed character is dropped until the overrun latch has been set and then cleared by `err_clr`.
- R8: `par_err`, `frm_err` and `ovr_err` stay set until an `err_clr` pulse, which clears all three in the following cycle.
- R9: `rx_irq` is 1 in the cycle after an edge where `rx_int_en`=1 and either the queue is non-empty after that edge, or `start_int_en`=1 and `start_det`=1. With `rx_int_en`=0, `rx_irq` is 0.
- R10: A character that arrives in the same cycle as a read of a full queue is stored, and no overrun is tagged.
- R11: Synchronous reset clears `data_full`, all three error latches, `rx_irq` and the intake freeze.
- R12: Characters are read out in arrival order, and `data_rd` moves the head to the next entry within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chr_valid | input | 1 | Character-complete strobe |
| chr_data | input | 8 | Assembled data bits |
| chr_par | input | 1 | Sampled parity bit |
| chr_stop | input | 1 | Sampled stop bit |
| start_det | input | 1 | Start-bit detect pulse |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| rx_int_en | input | 1 | Receive interrupt enable |
| start_int_en | input | 1 | Interrupt on start bit enable |
| data_rd | input | 1 | Read strobe, pops the head |
| err_clr | input | 1 | Clear pulse for the error latches |
| rd_data | output | 8 | Head entry data |
| data_full | output | 1 | Data-available flag |
| ovr_err | output | 1 | Sticky overrun latch |
| par_err | output | 1 | Sticky parity latch |
| frm_err | output | 1 | Sticky framing latch |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A character strobe and a read strobe can fall in the same cycle while all four entries are occupied. Whether the block then stores the character or flags an overrun depends on both strobes together. The bench fills the queue, asserts both strobes on one edge, and then drains the queue. It judges the result by the order of the data that comes out and by `ovr_err` staying 0. In the contrasting case, the same push without a read must drop the character and freeze intake.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_bad;
    logic              frm_bad;
  } rxq_ent_t;
endpackage

// File: rtl/rxq_char_tagger.sv
module rxq_char_tagger
  import uart_rxq_pkg::*;
(
  input  logic [CHAR_W-1:0] char_bits,
  input  logic              par_bit,
  input  logic              stop_bit,
  input  logic              par_chk_en,
  input  logic              par_odd_sel,
  output rxq_ent_t          ent
);
  logic ones_odd;

  // XOR over data and parity bit: 1 when the total count of ones is odd
  assign ones_odd = (^char_bits) ^ par_bit;

  always_comb begin
    ent.data    = char_bits;
    ent.par_bad = par_chk_en & (ones_odd != par_odd_sel);
    ent.frm_bad = ~stop_bit;
  end
endmodule

// File: rtl/rxq_tag_fifo.sv
module rxq_tag_fifo
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push_req,
  input  rxq_ent_t push_ent,
  input  logic     pop_req,
  input  logic     intake_hold,
  output rxq_ent_t head_ent,
  output logic     head_ovr,
  output logic     not_empty,
  output logic     not_empty_nxt,
  output logic     pop_fire,
  output logic     ovf_pulse
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  rxq_ent_t         mem [DEPTH];
  logic [DEPTH-1:0] ovr_tag;
  logic [AW-1:0]    wp, rp, wp_prev;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             is_full, accept;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign is_full   = (cnt == CNT_MAX);
  assign not_empty = (cnt != '0);
  assign pop_fire  = pop_req & not_empty;
  assign accept    = push_req & ~intake_hold & (~is_full | pop_fire);
  assign ovf_pulse = push_req & ~intake_hold & is_full & ~pop_fire;
  assign wp_prev   = (wp == '0) ? PTR_LAST : wp - 1'b1;

  always_comb begin
    cnt_nxt = cnt;
    case ({accept, pop_fire})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  assign not_empty_nxt = (cnt_nxt != '0);

  // data and error tags: plain write port, no reset, RAM style
  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      ovr_tag <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (accept) begin
        wp           <= ptr_inc(wp);
        ovr_tag[wp]  <= 1'b0;
      end
      if (ovf_pulse) ovr_tag[wp_prev] <= 1'b1;
      if (pop_fire)  rp <= ptr_inc(rp);
    end
  end

  assign head_ent = mem[rp];
  assign head_ovr = ovr_tag[rp];

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (is_full && push_req && !pop_req) |=> (cnt == CNT_MAX));

  assert_swap_keeps_full_R10: assert property (@(posedge clk) disable iff (rst)
    (is_full && push_req && !intake_hold && pop_req) |=> (cnt == CNT_MAX));

  assert_hold_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (intake_hold && push_req && !pop_req) |=> (cnt == $past(cnt)));

  assert_pop_keeps_data_R1: assert property (@(posedge clk) disable iff (rst)
    (pop_req && cnt > 1) |=> not_empty);
endmodule

// File: rtl/rxq_status.sv
module rxq_status (
  input  logic clk,
  input  logic rst,
  input  logic not_empty,
  input  logic not_empty_nxt,
  input  logic head_pe,
  input  logic head_fe,
  input  logic head_ovr,
  input  logic pop_fire,
  input  logic err_clr,
  input  logic ovf_pulse,
  input  logic start_det,
  input  logic rx_int_en,
  input  logic start_int_en,
  output logic par_lat,
  output logic frm_lat,
  output logic ovr_lat,
  output logic intake_hold,
  output logic data_full,
  output logic rx_irq
);
  logic head_seen;
  logic tag_load;

  // a head entry's tags are taken once, the first cycle it is the head
  assign tag_load = not_empty & ~head_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_seen   <= 1'b0;
      par_lat     <= 1'b0;
      frm_lat     <= 1'b0;
      ovr_lat     <= 1'b0;
      intake_hold <= 1'b0;
      data_full   <= 1'b0;
      rx_irq      <= 1'b0;
    end else begin
      if (pop_fire)      head_seen <= 1'b0;
      else if (tag_load) head_seen <= 1'b1;

      par_lat <= (par_lat & ~err_clr) | (tag_load & head_pe);
      frm_lat <= (frm_lat & ~err_clr) | (tag_load & head_fe);
      ovr_lat <= (ovr_lat & ~err_clr) | (tag_load & head_ovr);

      if (ovf_pulse)               intake_hold <= 1'b1;
      else if (err_clr && ovr_lat) intake_hold <= 1'b0;

      data_full <= not_empty_nxt;
      rx_irq    <= rx_int_en & (not_empty_nxt | (start_int_en & start_det));
    end
  end

  assert_sticky_pe_R8: assert property (@(posedge clk) disable iff (rst)
    (par_lat && !err_clr) |=> par_lat);

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !tag_load) |=> (!par_lat && !frm_lat && !ovr_lat));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !rx_int_en |=> !rx_irq);

  assert_hold_on_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> intake_hold);
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chr_valid,
  input  logic [CHAR_W-1:0] chr_data,
  input  logic              chr_par,
  input  logic              chr_stop,
  input  logic              start_det,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_int_en,
  input  logic              start_int_en,
  input  logic              data_rd,
  input  logic              err_clr,
  output logic [CHAR_W-1:0] rd_data,
  output logic              data_full,
  output logic              ovr_err,
  output logic              par_err,
  output logic              frm_err,
  output logic              rx_irq
);
  rxq_ent_t new_ent, head_ent;
  logic head_ovr, not_empty, not_empty_nxt, pop_fire, ovf_pulse, intake_hold;

  rxq_char_tagger i_tagger (
    .char_bits   (chr_data),
    .par_bit     (chr_par),
    .stop_bit    (chr_stop),
    .par_chk_en  (par_en),
    .par_odd_sel (par_odd),
    .ent         (new_ent)
  );

  rxq_tag_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk           (clk),
    .rst           (rst),
    .push_req      (chr_valid),
    .push_ent      (new_ent),
    .pop_req       (data_rd),
    .intake_hold   (intake_hold),
    .head_ent      (head_ent),
    .head_ovr      (head_ovr),
    .not_empty     (not_empty),
    .not_empty_nxt (not_empty_nxt),
    .pop_fire      (pop_fire),
    .ovf_pulse     (ovf_pulse)
  );

  rxq_status i_status (
    .clk           (clk),
    .rst           (rst),
    .not_empty     (not_empty),
    .not_empty_nxt (not_empty_nxt),
    .head_pe       (head_ent.par_bad),
    .head_fe       (head_ent.frm_bad),
    .head_ovr      (head_ovr),
    .pop_fire      (pop_fire),
    .err_clr       (err_clr),
    .ovf_pulse     (ovf_pulse),
    .start_det     (start_det),
    .rx_int_en     (rx_int_en),
    .start_int_en  (start_int_en),
    .par_lat       (par_err),
    .frm_lat       (frm_err),
    .ovr_lat       (ovr_err),
    .intake_hold   (intake_hold),
    .data_full     (data_full),
    .rx_irq        (rx_irq)
  );

  assign rd_data = head_ent.data;

  assert_flag_tracks_store_R1: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && !intake_hold && !data_rd && !ovf_pulse) |=> data_full);
endmodule

// File: tb/test_uart_rxq_top.sv
module test_uart_rxq_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chr_valid = 1'b0;
  logic [7:0] chr_data = 8'h00;
  logic       chr_par = 1'b0;
  logic       chr_stop = 1'b1;
  logic       start_det = 1'b0;
  logic       par_en = 1'b1;
  logic       par_odd = 1'b0;
  logic       rx_int_en = 1'b0;
  logic       start_int_en = 1'b0;
  logic       data_rd = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] rd_data;
  logic       data_full, ovr_err, par_err, frm_err, rx_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rxq_top i_uart_rxq_top (
    .clk(clk), .rst(rst), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_par(chr_par), .chr_stop(chr_stop), .start_det(start_det),
    .par_en(par_en), .par_odd(par_odd), .rx_int_en(rx_int_en),
    .start_int_en(start_int_en), .data_rd(data_rd), .err_clr(err_clr),
    .rd_data(rd_data), .data_full(data_full), .ovr_err(ovr_err),
    .par_err(par_err), .frm_err(frm_err), .rx_irq(rx_irq)
  );

  // row: valid, data, par, stop, rd, clr | full, data, pe, fe, oe
  localparam logic [24:0] VEC [10] = '{
    {1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'h03, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
    {1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h03, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic p,
                     input logic s, input logic rd, input logic clr);
    chr_valid = v; chr_data = d; chr_par = p; chr_stop = s;
    data_rd = rd; err_clr = clr;
    @(posedge clk);
    @(negedge clk);
    chr_valid = 1'b0; data_rd = 1'b0; err_clr = 1'b0; start_det = 1'b0;
  endtask

  task automatic push_good(input logic [7:0] d);
    cyc(1'b1, d, ^d, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    par_en = 1'b1; par_odd = 1'b0; rx_int_en = 1'b0; start_int_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    chk("R11 full", {7'd0, data_full}, 8'h00);
    chk("R11 errs", {5'd0, ovr_err, par_err, frm_err}, 8'h00);
    chk("R11 irq", {7'd0, rx_irq}, 8'h00);

    // table walk: R1, R2, R3, R4, R5, R8, R12
    for (int i = 0; i < 10; i++) begin
      cyc(VEC[i][24], VEC[i][23:16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]);
      chk($sformatf("R1 R2 row%0d full", i), {7'd0, data_full}, {7'd0, VEC[i][11]});
      if (VEC[i][11]) chk($sformatf("R12 row%0d data", i), rd_data, VEC[i][10:3]);
      chk($sformatf("R4 R5 R8 row%0d pe", i), {7'd0, par_err}, {7'd0, VEC[i][2]});
      chk($sformatf("R3 R5 row%0d fe", i), {7'd0, frm_err}, {7'd0, VEC[i][1]});
      chk($sformatf("R5 row%0d oe", i), {7'd0, ovr_err}, {7'd0, VEC[i][0]});
    end

    // overrun and freeze: R6, R7
    do_reset();
    for (int k = 0; k < 4; k++) push_good(8'hA0 + 8'(k));
    push_good(8'hA4);
    chk("R6 still full", {7'd0, data_full}, 8'h01);
    chk("R6 head kept", rd_data, 8'hA0);
    chk("R5 oe not at head yet", {7'd0, ovr_err}, 8'h00);
    push_good(8'hA5);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R12 pop A1", rd_data, 8'hA1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R12 pop A2", rd_data, 8'hA2);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6 tagged A3 head", rd_data, 8'hA3);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 oe latched", {7'd0, ovr_err}, 8'h01);
    push_good(8'hA6);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R7 A4 A5 A6 dropped", {7'd0, data_full}, 8'h00);
    chk("R8 oe sticky", {7'd0, ovr_err}, 8'h01);
    push_good(8'hB7);
    chk("R7 frozen before clear", {7'd0, data_full}, 8'h00);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    chk("R8 oe cleared", {7'd0, ovr_err}, 8'h00);
    push_good(8'hA7);
    chk("R7 intake resumed", {7'd0, data_full}, 8'h01);
    chk("R7 resumed data", rd_data, 8'hA7);

    // same-cycle push and read while full: R10
    do_reset();
    for (int k = 0; k < 4; k++) push_good(8'hB0 + 8'(k));
    cyc(1'b1, 8'hB4, ^8'hB4, 1'b1, 1'b1, 1'b0);
    chk("R10 head after swap", rd_data, 8'hB1);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R10 no overrun", {7'd0, ovr_err}, 8'h00);
    for (int k = 2; k < 5; k++) begin
      cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
      chk("R10 R12 drain order", rd_data, 8'hB0 + 8'(k));
    end
    chk("R10 ovr after drain", {7'd0, ovr_err}, 8'h00);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 empty after last read", {7'd0, data_full}, 8'h00);

    // interrupt: R9
    do_reset();
    push_good(8'hC0);
    chk("R9 irq disabled", {7'd0, rx_irq}, 8'h00);
    rx_int_en = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 irq on full", {7'd0, rx_irq}, 8'h01);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R9 irq drops when empty", {7'd0, rx_irq}, 8'h00);
    start_int_en = 1'b1;
    start_det = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 irq on start", {7'd0, rx_irq}, 8'h01);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 start irq is a pulse", {7'd0, rx_irq}, 8'h00);
    start_int_en = 1'b0;
    start_det = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 start ignored when option off", {7'd0, rx_irq}, 8'h00);

    // parity sense and enable: R4
    do_reset();
    par_odd = 1'b1;
    cyc(1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 odd sense good", {7'd0, par_err}, 8'h00);
    cyc(1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 odd sense bad", {7'd0, par_err}, 8'h01);
    chk("R2 bad char stored", rd_data, 8'h01);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8 pe cleared", {7'd0, par_err}, 8'h00);
    par_en = 1'b0; par_odd = 1'b0;
    cyc(1'b1, 8'h03, 1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 check disabled", {7'd0, par_err}, 8'h00);
    chk("R4 char present", rd_data, 8'h03);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule